// File: doc/BRIEF.md
# Inter-Node Doorbell Interrupt Register Block

This block is the software-visible control face of a shared-memory peer device. It decodes reads and writes on a simple 32-bit memory-mapped bus, tells software its own node number once the device is usable, and lets software ring a doorbell in another node by writing one word that carries a destination node number and a vector. Each doorbell write leaves the block as a one-cycle request toward a transport that lies outside this block.

Doorbell events that arrive from other nodes are handled in one of two ways, chosen by a mode input. In level mode, an event latches a status flag, and a level interrupt line follows the AND of that flag with a mask bit. In message mode, the event fires a one-cycle pulse on the output for the selected vector, and the flag and mask play no part. Vectors outside the configured count are dropped and recorded in a sticky error flag.

Both streams, the outgoing doorbell request and the incoming event, are valid-only. There is no ready signal and no back-pressure. Whatever the block presents for a cycle is taken in that cycle, and an incoming event is consumed on the clock edge where its valid is high. The bus has no wait states. Read data is valid combinationally in the same cycle as the select.

Top module: `peer_bell_regs`

## Requirements
- R1: While reset is low, and after it, the mask, status and vector error flag are all zero. The doorbell request valid, the interrupt line and all vector pulses are low.
- R2: A read at byte offset 8 returns 0xFFFFFFFF while `dev_ready` is low. While it is high, the read returns `node_id` zero-extended to 32 bits.
- R3: A write at byte offset 12 raises `ring_valid` for exactly the next cycle. In that cycle, `ring_dest` holds write data bits 31:16 and `ring_vec` holds bits 15:0.
- R4: In level mode (`msg_mode`=0), an incoming event sets the status register (byte offset 4) to exactly 1, whatever its vector.
- R5: In level mode, `irq_line` is high exactly when mask bit 0 is 1 and status is 1. The other mask bits are stored and read back at byte offset 0, but they have no effect. In message mode, `irq_line` is low.
- R6: In level mode, incoming events produce no vector pulses. The vector value has no effect on the result.
- R7: In message mode, an event with vector v below NVEC drives `msg_pulse` to the value 1<<v for exactly one cycle, on the cycle after the event. The status register is left unchanged.
- R8: In message mode, an event with vector NVEC or above produces no pulse and sets `vec_err`. `vec_err` stays set until reset.
- R9: A read of the status register returns its current value and clears it to zero. If a level-mode event arrives in the same cycle, the set wins and status becomes 1.
- R10: Writes at byte offsets 4 and 8, and at any unmapped offset, change nothing and raise no doorbell request. Reads of offset 12 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_mode | input | 1 | 1 selects per-vector message pulses, 0 selects the level interrupt |
| dev_ready | input | 1 | High once the node number is valid |
| node_id | input | 16 | Own node number |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ring_valid | output | 1 | Outgoing doorbell request, one cycle |
| ring_dest | output | 16 | Destination node of the request |
| ring_vec | output | 16 | Vector of the request |
| evt_valid | input | 1 | Incoming doorbell event |
| evt_vec | input | 16 | Vector of the incoming event |
| irq_line | output | 1 | Level interrupt |
| msg_pulse | output | NVEC | One-cycle pulse per vector |
| vec_err | output | 1 | Sticky flag for an out-of-range incoming vector |

## Verification
The hardest case to reach from the ports is the one where a status read and an incoming level-mode event land on the same clock edge. The read must return the old value, and the flag must end up set. A bench driving only the bus and a loopback cannot line these up, so it injects an event directly on the event input in the same cycle that it holds a status read. It then checks the returned data, the interrupt line, and a second read. Sweeping every vector from 0 to past NVEC in message mode reaches the drop path and the sticky error flag. Switching mode while the flag is latched shows that the mask and flag have no effect in message mode.

// File: rtl/peer_bell_pkg.sv
package peer_bell_pkg;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int VEC_W  = 16;

  localparam int OFF_MASK = 0;
  localparam int OFF_STAT = 4;
  localparam int OFF_POS  = 8;
  localparam int OFF_BELL = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_POS,
    SEL_BELL
  } reg_sel_e;

  typedef struct packed {
    logic [ID_W-1:0]  dest;
    logic [VEC_W-1:0] vec;
  } bell_word_t;
endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
  import peer_bell_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              wr_mask,
  output logic              wr_bell,
  output logic              rd_stat
);
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFF_MASK))      sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (bus_addr == ADDR_W'(OFF_POS))  sel = SEL_POS;
    else if (bus_addr == ADDR_W'(OFF_BELL)) sel = SEL_BELL;
  end

  assign wr_mask = bus_sel && bus_wr && (sel == SEL_MASK);
  assign wr_bell = bus_sel && bus_wr && (sel == SEL_BELL);
  assign rd_stat = bus_sel && !bus_wr && (sel == SEL_STAT);
endmodule

// File: rtl/pbr_bell_tx.sv
module pbr_bell_tx
  import peer_bell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_bell,
  input  logic [DATA_W-1:0] wdata,
  output logic              ring_valid,
  output logic [ID_W-1:0]   ring_dest,
  output logic [VEC_W-1:0]  ring_vec
);
  bell_word_t word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_valid <= 1'b0;
      word_q     <= '0;
    end else begin
      ring_valid <= wr_bell;
      if (wr_bell) word_q <= bell_word_t'(wdata);
    end
  end

  assign ring_dest = word_q.dest;
  assign ring_vec  = word_q.vec;
endmodule

// File: rtl/pbr_pin_irq.sv
module pbr_pin_irq
  import peer_bell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic              evt_valid,
  input  logic              rd_stat,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq_line
);
  logic set_evt;
  assign set_evt = evt_valid && !msg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (set_evt)      status_q <= DATA_W'(1);
      else if (rd_stat) status_q <= '0;
    end
  end

  assign irq_line = !msg_mode && mask_q[0] && status_q[0];
endmodule

// File: rtl/pbr_msg_irq.sv
module pbr_msg_irq
  import peer_bell_pkg::*;
#(
  parameter int NVEC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_mode,
  input  logic             evt_valid,
  input  logic [VEC_W-1:0] evt_vec,
  output logic [NVEC-1:0]  msg_pulse,
  output logic             vec_err
);
  localparam logic [VEC_W:0] LIMIT = (VEC_W+1)'(NVEC);

  logic take;
  logic in_range;
  assign take     = msg_mode && evt_valid;
  assign in_range = {1'b0, evt_vec} < LIMIT;

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msg_pulse[g] <= 1'b0;
      else        msg_pulse[g] <= take && (evt_vec == VEC_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 vec_err <= 1'b0;
    else if (take && !in_range) vec_err <= 1'b1;
  end
endmodule

// File: rtl/peer_bell_regs.sv
module peer_bell_regs
  import peer_bell_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NVEC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic              dev_ready,
  input  logic [15:0]       node_id,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ring_valid,
  output logic [15:0]       ring_dest,
  output logic [15:0]       ring_vec,
  input  logic              evt_valid,
  input  logic [15:0]       evt_vec,
  output logic              irq_line,
  output logic [NVEC-1:0]   msg_pulse,
  output logic              vec_err
);
  reg_sel_e          sel;
  logic              wr_mask, wr_bell, rd_stat;
  logic [DATA_W-1:0] mask_q, status_q;

  pbr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .sel(sel), .wr_mask(wr_mask), .wr_bell(wr_bell), .rd_stat(rd_stat)
  );

  pbr_bell_tx u_tx (
    .clk(clk), .rst_n(rst_n), .wr_bell(wr_bell), .wdata(bus_wdata),
    .ring_valid(ring_valid), .ring_dest(ring_dest), .ring_vec(ring_vec)
  );

  pbr_pin_irq u_pin (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .evt_valid(evt_valid),
    .rd_stat(rd_stat), .wr_mask(wr_mask), .wdata(bus_wdata),
    .mask_q(mask_q), .status_q(status_q), .irq_line(irq_line)
  );

  pbr_msg_irq #(.NVEC(NVEC)) u_msg (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .evt_valid(evt_valid),
    .evt_vec(evt_vec), .msg_pulse(msg_pulse), .vec_err(vec_err)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (sel)
        SEL_MASK: bus_rdata = mask_q;
        SEL_STAT: bus_rdata = status_q;
        SEL_POS:  bus_rdata = dev_ready ? {16'h0, node_id} : '1;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int ADDR_W = 10,
  parameter int NVEC   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_mode,
  input logic              dev_ready,
  input logic [15:0]       node_id,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ring_valid,
  input logic [15:0]       ring_dest,
  input logic [15:0]       ring_vec,
  input logic              evt_valid,
  input logic [15:0]       evt_vec,
  input logic              irq_line,
  input logic [NVEC-1:0]   msg_pulse,
  input logic              vec_err,
  input logic [31:0]       status_q
);
  logic bell_wr, pos_rd, stat_rd, bell_rd, pin_evt, msg_ok, msg_bad;
  assign bell_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(12));
  assign pos_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(8));
  assign stat_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(4));
  assign bell_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(12));
  assign pin_evt = evt_valid && !msg_mode;
  assign msg_ok  = evt_valid && msg_mode && (32'(evt_vec) < NVEC);
  assign msg_bad = evt_valid && msg_mode && (32'(evt_vec) >= NVEC);

  // R1
  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!ring_valid && msg_pulse == '0 && !vec_err && !irq_line));
  a_r2_pos_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pos_rd && !dev_ready |-> bus_rdata == 32'hFFFF_FFFF);
  a_r2_pos_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pos_rd && dev_ready |-> bus_rdata == {16'h0, node_id});
  a_r3_bell_fields: assert property (@(posedge clk) disable iff (!rst_n)
    bell_wr |=> ring_valid && ring_dest == $past(bus_wdata[31:16])
                && ring_vec == $past(bus_wdata[15:0]));
  // R3 and R10: no request without a doorbell write
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bell_wr |=> !ring_valid);
  a_r4_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |=> status_q == 32'd1);
  a_r5_msg_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |-> !irq_line);
  a_r6_pin_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> msg_pulse == '0);
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msg_pulse));
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ok |=> msg_pulse == (NVEC'(1) << $past(evt_vec)));
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode && !stat_rd |=> $stable(status_q));
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    msg_bad |=> vec_err && msg_pulse == '0);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |=> vec_err);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !pin_evt |=> status_q == 32'd0);
  a_r10_bell_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bell_rd |-> bus_rdata == 32'd0);
endmodule

bind peer_bell_regs pbr_checker #(.ADDR_W(ADDR_W), .NVEC(NVEC)) u_chk (.*);

// File: tb/peer_bell_regs_bench.sv
`timescale 1ns/1ps
module peer_bell_regs_bench;
  localparam int ADDR_W = 10;
  localparam int NVEC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_mode = 1'b0, dev_ready = 1'b0;
  logic [15:0] node_id = 16'h1234;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ring_valid;
  logic [15:0] ring_dest, ring_vec;
  logic evt_valid;
  logic [15:0] evt_vec;
  logic inj_valid = 1'b0;
  logic [15:0] inj_vec = '0;
  logic irq_line, vec_err;
  logic [NVEC-1:0] msg_pulse;

  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  assign evt_valid = ring_valid | inj_valid;
  assign evt_vec   = inj_valid ? inj_vec : ring_vec;

  peer_bell_regs #(.ADDR_W(ADDR_W), .NVEC(NVEC)) u_peer_bell_regs (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .dev_ready(dev_ready),
    .node_id(node_id), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ring_valid(ring_valid),
    .ring_dest(ring_dest), .ring_vec(ring_vec), .evt_valid(evt_valid),
    .evt_vec(evt_vec), .irq_line(irq_line), .msg_pulse(msg_pulse),
    .vec_err(vec_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
    #1 data = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic inject(input logic [15:0] v);
    @(negedge clk);
    inj_valid = 1'b1; inj_vec = v;
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] masks [5];
    logic [15:0] ids [4];
    logic [15:0] vecs [4];
    logic err_exp;
    masks = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFE, 32'hFFFF_FFFF};
    ids   = '{16'h0, 16'h1, 16'h1234, 16'hFFFF};
    vecs  = '{16'h0, 16'h1, 16'h7, 16'hFFFF};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_line), 0);
    chk("R1 ring_valid", 32'(ring_valid), 0);
    chk("R1 pulses", 32'(msg_pulse), 0);
    chk("R1 vec_err", 32'(vec_err), 0);
    rd(0, d); chk("R1 mask", d, 0);
    rd(4, d); chk("R1 status", d, 0);

    // R2 position register
    rd(8, d); chk("R2 not ready", d, 32'hFFFF_FFFF);
    dev_ready = 1'b1;
    foreach (ids[i]) begin
      node_id = ids[i];
      rd(8, d); chk("R2 ready id", d, {16'h0, ids[i]});
    end

    // R5 / R4 / R9 mask sweep with injected events
    foreach (masks[i]) begin
      wr(0, masks[i]);
      rd(0, d); chk("R5 mask readback", d, masks[i]);
      inject(16'(i * 3));
      chk("R5 irq follows mask bit0", 32'(irq_line), 32'(masks[i][0]));
      rd(4, d); chk("R4 status is one", d, 1);
      chk("R9 cleared irq", 32'(irq_line), 0);
      rd(4, d); chk("R9 status cleared", d, 0);
    end

    // R3 / R6 loopback in level mode
    wr(0, 1);
    foreach (vecs[i]) begin
      wr(12, {16'(16'hA0 + i), vecs[i]});
      chk("R3 valid", 32'(ring_valid), 1);
      chk("R3 dest", 32'(ring_dest), 32'(16'hA0 + i));
      chk("R3 vec", 32'(ring_vec), 32'(vecs[i]));
      @(negedge clk);
      chk("R3 single cycle", 32'(ring_valid), 0);
      chk("R6 irq any vector", 32'(irq_line), 1);
      chk("R6 no pulse", 32'(msg_pulse), 0);
      rd(4, d); chk("R6 status", d, 1);
    end

    // R7 / R8 message mode sweep
    msg_mode = 1'b1;
    err_exp = 1'b0;
    for (int v = 0; v <= NVEC + 2; v++) begin
      wr(12, {16'h5, 16'(v)});
      @(negedge clk);
      if (v >= NVEC) err_exp = 1'b1;
      chk("R7 pulse", 32'(msg_pulse), (v < NVEC) ? (32'd1 << v) : 32'd0);
      chk("R8 vec_err", 32'(vec_err), 32'(err_exp));
      chk("R5 irq low in msg mode", 32'(irq_line), 0);
      @(negedge clk);
      chk("R7 pulse one cycle", 32'(msg_pulse), 0);
    end
    wr(12, {16'h5, 16'd1});
    @(negedge clk);
    chk("R8 sticky after good vector", 32'(vec_err), 1);
    chk("R7 pulse after error", 32'(msg_pulse), 32'd2);
    msg_mode = 1'b0;
    #1 chk("R7 status untouched irq", 32'(irq_line), 0);
    rd(4, d); chk("R7 status untouched", d, 0);

    // R5 mode switch with latched status
    inject(16'h3);
    chk("R5 irq pin", 32'(irq_line), 1);
    msg_mode = 1'b1;
    #1 chk("R5 msg mode hides irq", 32'(irq_line), 0);
    msg_mode = 1'b0;
    #1 chk("R5 irq back", 32'(irq_line), 1);
    rd(4, d);

    // R9 read and event on the same edge
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(4);
    inj_valid = 1'b1; inj_vec = 16'h9;
    #1 d = bus_rdata;
    chk("R9 same-cycle read old value", d, 0);
    @(negedge clk);
    bus_sel = 1'b0; inj_valid = 1'b0;
    chk("R9 set wins irq", 32'(irq_line), 1);
    rd(4, d); chk("R9 set wins status", d, 1);

    // R10 ignored writes and zero reads
    wr(0, 32'h0000_0031);
    node_id = 16'h00C3;
    wr(8, 32'h1111_2222);  chk("R10 pos write no ring", 32'(ring_valid), 0);
    wr(4, 32'h1);          chk("R10 status write no ring", 32'(ring_valid), 0);
    wr(16, 32'hDEAD_BEEF); chk("R10 unmapped no ring", 32'(ring_valid), 0);
    wr(1020, 32'hFFFF_FFFF); chk("R10 top unmapped no ring", 32'(ring_valid), 0);
    chk("R10 status write no irq", 32'(irq_line), 0);
    rd(0, d);  chk("R10 mask unchanged", d, 32'h31);
    rd(4, d);  chk("R10 status unchanged", d, 0);
    rd(8, d);  chk("R10 pos unchanged", d, 32'h00C3);
    rd(12, d); chk("R10 doorbell reads zero", d, 0);
    rd(16, d); chk("R10 unmapped reads zero", d, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule